// File: doc/BRIEF.md
# Codec Serial Control-Frame Port

This block is the serial side of an audio codec that sits on a time-division multiplexed bus. The bus carries one 64-bit frame per frame sync. Each frame is eight byte-wide timeslots, sent most significant bit first and starting with the first slot. The host marks each serial bit with a one-cycle `bit_en` strobe and marks the first bit of every frame with `fsync`. The codec shifts the host bits in on `sdin`. At the same time it shifts its return frame out on `sdout`, and the host samples it at each strobe.

A mode input selects how each frame is read. In control mode, the first four slots hold writable configuration bytes and the last four hold returned status. A configuration does not take effect at once. The host first sends a frame with the latch bit set, then two further complete control frames that also have the latch bit set. The configuration commits from the last of those frames. In data mode, the first four slots carry a left and a right 16-bit sample, and the last four slots carry output and input settings, which apply at once.

Received samples leave on a valid/ready stream. Capture samples enter on a second valid/ready stream and go back to the host in the first four slots of data-mode frames. Each stream has one holding register. While `pcm_valid` is high and `pcm_ready` is low, the output sample is held stable, and the samples of any further data frames are discarded. `cap_ready` is high only while the capture register is empty. A capture sample is consumed when a data-mode return frame is loaded, and that frees the register.

Top module: `codec_frame_port`

## Requirements
- R1: After reset, `pcm_valid` is 0, `ctrl_word` and `settings` are 0, `cap_ready` is 1 and `sdout` is 0.
- R2: In control mode, bit 2 of slot 1 (frame bit 58) is the latch bit. A frame with it set arms the latch. The second further complete control frame with it set commits that frame's slots 1-4 to `ctrl_word` (slot 1 in bits 31:24).
- R3: A complete control frame with the latch bit clear, or any complete data frame, disarms the latch and restarts the count.
- R4: Reserved bits read as zero in `ctrl_word`: bits 1:0 of slot 1 and bit 6 of slot 2, so `ctrl_word` is the written value AND 32'hFCBF_FFFF.
- R5: A control-mode return frame carries zeros in slots 1-4, 7 and 8. Slot 5 is the status byte: bit 7 = `cal_busy`, bit 5 = 1, bit 2 = the latch bit of the last complete control frame, all other bits 0. Slot 6 is the version byte: upper nibble 0, lower nibble the REVISION parameter.
- R6: A complete data frame loads slots 5-8 into `settings` at once. Slot 6 bit 7 and slot 7 bit 5 are read-only and stored as 0. The data-mode return frame echoes `settings` in slots 5-8, with slot 6 bit 7 set to `cal_busy` and slot 7 bit 5 set to `adc_over`.
- R7: A complete data frame presents slots 1-4 on `pcm_data` (left sample in bits 31:16) with `pcm_valid`, if the holding register is free or is being accepted in that cycle. Otherwise the new sample is discarded, and the held sample stays stable until `pcm_ready`.
- R8: A capture word accepted on `cap_valid`/`cap_ready` is returned in slots 1-4 of the next data-mode return frame loaded after it. Loading that frame empties the holding register.
- R9: `mode_sel` is sampled at the end of each complete frame. It selects how the following frame is read and how the return frame sent during it is built, so a change in the middle of a frame does not affect that frame.
- R10: A frame that is cut short by an early `fsync`, or that starts without `fsync`, is ignored: it neither counts toward nor disarms the latch, and it loads nothing.
- R11: `ctrl_upd` pulses high for exactly one cycle, in the cycle in which `ctrl_word` takes a committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| fsync | input | 1 | Marks the strobe of frame bit 0 |
| sdin | input | 1 | Serial data from the host |
| sdout | output | 1 | Serial return data, valid before each strobe |
| mode_sel | input | 1 | 0 selects control mode, 1 selects data mode |
| cal_busy | input | 1 | Calibration busy flag, returned in status |
| adc_over | input | 1 | Converter over-range flag, returned in data mode |
| pcm_valid | output | 1 | Received sample available |
| pcm_ready | input | 1 | Downstream accepts the sample |
| pcm_data | output | 32 | Left sample in 31:16, right sample in 15:0 |
| cap_valid | input | 1 | Capture sample offered |
| cap_ready | output | 1 | Capture holding register is empty |
| cap_data | input | 32 | Capture sample for slots 1-4 |
| ctrl_word | output | 32 | Committed control slots 1-4 |
| ctrl_upd | output | 1 | One-cycle pulse on commit |
| settings | output | 32 | Data-mode slots 5-8 |

## Verification
The assertions assume three things about the inputs. `bit_en` is a single-cycle strobe separated by idle cycles. `pcm_ready` is a level that can arrive at any time. `fsync` only ever comes together with a strobe. The stimulus follows these rules: it spaces every serial bit two cycles apart, raises `fsync` only together with a strobe, and changes `mode_sel`, `cal_busy` and `adc_over` only between frames. It also sends one frame that is deliberately cut short, to exercise resynchronisation.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  localparam int SLOT_W    = 8;
  localparam int NUM_SLOTS = 8;
  localparam int FRAME_W   = SLOT_W * NUM_SLOTS;
  localparam int HALF_W    = FRAME_W / 2;
  // latch bit: bit 2 of the first slot, counted from the frame's MSB
  localparam int LATCH_POS = FRAME_W - 1 - (SLOT_W - 1 - 2);

  typedef enum logic {
    MODE_CTRL = 1'b0,
    MODE_DATA = 1'b1
  } port_mode_e;

  localparam logic [HALF_W-1:0] CTRL_WMASK = 32'hFCBF_FFFF;
  localparam logic [HALF_W-1:0] SET_WMASK  = 32'hFF7F_DFFF;

  function automatic logic [SLOT_W-1:0] status_byte(input logic busy, input logic echo);
    status_byte = {busy, 1'b0, 1'b1, 2'b00, echo, 2'b00};
  endfunction
endpackage

// File: rtl/cfp_bit_timer.sv
module cfp_bit_timer #(
  parameter int FRAME_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_en,
  input  logic                       fsync,
  output logic [$clog2(FRAME_W)-1:0] nxt_idx,
  output logic                       frame_done
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_W - 1);

  logic             ok_q;
  logic             ok_now;
  logic [IDX_W-1:0] cur;

  always_comb begin
    cur        = fsync ? '0 : nxt_idx;
    ok_now     = fsync | (ok_q & (nxt_idx != '0));
    frame_done = bit_en & ok_now & (cur == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_idx <= '0;
      ok_q    <= 1'b0;
    end else if (bit_en) begin
      nxt_idx <= (cur == LAST) ? '0 : cur + 1'b1;
      ok_q    <= ok_now;
    end
  end
endmodule

// File: rtl/cfp_rx_shift.sv
module cfp_rx_shift #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               sdin,
  output logic [FRAME_W-1:0] word
);
  logic [FRAME_W-2:0] sh_q;

  assign word = {sh_q, sdin};

  always_ff @(posedge clk) begin
    if (!rst_n)      sh_q <= '0;
    else if (bit_en) sh_q <= word[FRAME_W-2:0];
  end
endmodule

// File: rtl/cfp_latch_ctl.sv
module cfp_latch_ctl #(
  parameter int LATCH_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic is_ctrl,
  input  logic clb,
  output logic commit,
  output logic echo_nx
);
  localparam int CNT_W = (LATCH_FRAMES > 1) ? $clog2(LATCH_FRAMES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATCH_FRAMES - 1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             echo_q;

  always_comb begin
    commit  = frame_done & is_ctrl & clb & armed_q & (cnt_q == CNT_LAST);
    echo_nx = (frame_done & is_ctrl) ? clb : echo_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      echo_q  <= 1'b0;
    end else if (frame_done) begin
      if (is_ctrl) begin
        echo_q <= clb;
        if (!clb || commit) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else if (armed_q) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
        end
      end else begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/cfp_tx_frame.sv
module cfp_tx_frame #(
  parameter int FRAME_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [FRAME_W-1:0]         load_word,
  input  logic [$clog2(FRAME_W)-1:0] nxt_idx,
  output logic                       sdout
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] tx_q;

  assign sdout = tx_q[TOP - nxt_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)    tx_q <= '0;
    else if (load) tx_q <= load_word;
  end
endmodule

// File: rtl/codec_frame_port.sv
module codec_frame_port
  import codec_port_pkg::*;
#(
  parameter logic [3:0] REVISION     = 4'h2,
  parameter int         LATCH_FRAMES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        fsync,
  input  logic        sdin,
  output logic        sdout,
  input  logic        mode_sel,
  input  logic        cal_busy,
  input  logic        adc_over,
  output logic        pcm_valid,
  input  logic        pcm_ready,
  output logic [31:0] pcm_data,
  input  logic        cap_valid,
  output logic        cap_ready,
  input  logic [31:0] cap_data,
  output logic [31:0] ctrl_word,
  output logic        ctrl_upd,
  output logic [31:0] settings
);
  localparam int IDX_W = $clog2(FRAME_W);

  logic [IDX_W-1:0]   nxt_idx;
  logic               frame_done;
  logic [FRAME_W-1:0] rx_word;
  logic               commit;
  logic               echo_nx;
  port_mode_e         mode_q;
  logic               is_ctrl;
  logic [HALF_W-1:0]  set_nx;
  logic [HALF_W-1:0]  cap_hold;
  logic               cap_full;
  logic               consume;
  logic [FRAME_W-1:0] ret_word;

  cfp_bit_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .nxt_idx(nxt_idx), .frame_done(frame_done)
  );

  cfp_rx_shift #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdin(sdin), .word(rx_word)
  );

  assign is_ctrl = (mode_q == MODE_CTRL);

  cfp_latch_ctl #(.LATCH_FRAMES(LATCH_FRAMES)) u_latch (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .is_ctrl(is_ctrl),
    .clb(rx_word[LATCH_POS]), .commit(commit), .echo_nx(echo_nx)
  );

  // mode for the next frame is taken at the boundary
  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= MODE_CTRL;
    else if (frame_done) mode_q <= port_mode_e'(mode_sel);
  end

  // committed control slots
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      ctrl_upd  <= 1'b0;
    end else begin
      ctrl_upd <= commit;
      if (commit) ctrl_word <= rx_word[FRAME_W-1 -: HALF_W] & CTRL_WMASK;
    end
  end

  // data-mode settings
  assign set_nx = (frame_done && !is_ctrl) ? (rx_word[HALF_W-1:0] & SET_WMASK) : settings;

  always_ff @(posedge clk) begin
    if (!rst_n) settings <= '0;
    else        settings <= set_nx;
  end

  // received sample stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcm_valid <= 1'b0;
      pcm_data  <= '0;
    end else begin
      if (pcm_valid && pcm_ready) pcm_valid <= 1'b0;
      if (frame_done && !is_ctrl && (!pcm_valid || pcm_ready)) begin
        pcm_valid <= 1'b1;
        pcm_data  <= rx_word[FRAME_W-1 -: HALF_W];
      end
    end
  end

  // capture sample stream
  assign cap_ready = !cap_full;
  assign consume   = frame_done && (mode_sel == MODE_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_full <= 1'b0;
      cap_hold <= '0;
    end else begin
      if (consume) cap_full <= 1'b0;
      if (cap_valid && !cap_full) begin
        cap_full <= 1'b1;
        cap_hold <= cap_data;
      end
    end
  end

  // return frame for the next frame period
  always_comb begin
    if (mode_sel == MODE_DATA) begin
      ret_word = {cap_hold,
                  set_nx[31:24],
                  set_nx[23:16] | {cal_busy, 7'b0},
                  set_nx[15:8]  | {2'b0, adc_over, 5'b0},
                  set_nx[7:0]};
    end else begin
      ret_word = {{HALF_W{1'b0}},
                  status_byte(cal_busy, echo_nx),
                  {4'h0, REVISION},
                  {(2*SLOT_W){1'b0}}};
    end
  end

  cfp_tx_frame #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .load_word(ret_word),
    .nxt_idx(nxt_idx), .sdout(sdout)
  );
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_en,
  input logic        sdout,
  input logic        pcm_valid,
  input logic        pcm_ready,
  input logic [31:0] pcm_data,
  input logic [31:0] ctrl_word,
  input logic        ctrl_upd,
  input logic [31:0] settings
);
  // R7
  pcm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid && !pcm_ready |=> pcm_valid && $stable(pcm_data));

  // R11
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_upd |=> !ctrl_upd);

  // R2
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_upd |-> $stable(ctrl_word));

  // R4
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word & 32'h0340_0000) == 32'h0);

  // R6
  set_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settings & 32'h0080_2000) == 32'h0);

  // R9
  sdout_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sdout));
endmodule

bind codec_frame_port cfp_checker u_cfp_checker (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdout(sdout),
  .pcm_valid(pcm_valid), .pcm_ready(pcm_ready), .pcm_data(pcm_data),
  .ctrl_word(ctrl_word), .ctrl_upd(ctrl_upd), .settings(settings)
);

// File: tb/codec_frame_port_test.sv
module codec_frame_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic        sdout;
  logic        mode_sel = 1'b0, cal_busy = 1'b0, adc_over = 1'b0;
  logic        pcm_valid, pcm_ready = 1'b0;
  logic [31:0] pcm_data;
  logic        cap_valid = 1'b0, cap_ready;
  logic [31:0] cap_data = '0;
  logic [31:0] ctrl_word, settings;
  logic        ctrl_upd;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  codec_frame_port uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sdin(sdin),
    .sdout(sdout), .mode_sel(mode_sel), .cal_busy(cal_busy), .adc_over(adc_over),
    .pcm_valid(pcm_valid), .pcm_ready(pcm_ready), .pcm_data(pcm_data),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_data(cap_data),
    .ctrl_word(ctrl_word), .ctrl_upd(ctrl_upd), .settings(settings)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_idx;
  bit          m_sync;
  logic [63:0] m_sh, m_tx;
  bit          m_mode, m_echo, m_armed, m_upd, m_pv, m_cfull;
  int          m_cnt;
  logic [31:0] m_ctrl, m_set, m_pd, m_cap;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_sync = 0; m_sh = '0; m_tx = '0; m_mode = 0; m_echo = 0;
      m_armed = 0; m_upd = 0; m_pv = 0; m_cfull = 0; m_cnt = 0;
      m_ctrl = '0; m_set = '0; m_pd = '0; m_cap = '0;
    end else begin
      bit pfree, done, was_full;
      int cur;
      logic [63:0] w;
      pfree = !m_pv || pcm_ready;
      if (m_pv && pcm_ready) m_pv = 0;
      was_full = m_cfull;
      done = 0;
      m_upd = 0;
      w = {m_sh[62:0], sdin};
      if (bit_en) begin
        if (fsync) begin cur = 0; m_sync = 1; end
        else begin cur = m_idx; m_sync = m_sync && (m_idx != 0); end
        done = m_sync && (cur == 63);
        m_idx = (cur + 1) % 64;
        m_sh = w;
      end
      if (done) begin
        if (!m_mode) begin
          m_echo = w[58];
          if (!w[58]) begin m_armed = 0; m_cnt = 0; end
          else if (m_armed && m_cnt == 1) begin
            m_ctrl = w[63:32] & 32'hFCBF_FFFF; m_upd = 1; m_armed = 0; m_cnt = 0;
          end else if (m_armed) m_cnt++;
          else begin m_armed = 1; m_cnt = 0; end
        end else begin
          m_armed = 0; m_cnt = 0;
          m_set = w[31:0] & 32'hFF7F_DFFF;
          if (pfree) begin m_pv = 1; m_pd = w[63:32]; end
        end
        if (mode_sel) begin
          m_tx = {m_cap, m_set[31:24], m_set[23:16] | (cal_busy ? 8'h80 : 8'h00),
                  m_set[15:8] | (adc_over ? 8'h20 : 8'h00), m_set[7:0]};
          m_cfull = 0;
        end else begin
          m_tx = {32'h0, cal_busy, 2'b01, 2'b00, m_echo, 2'b00, 8'h02, 16'h0};
        end
        m_mode = mode_sel;
      end
      if (cap_valid && !was_full) begin m_cfull = 1; m_cap = cap_data; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 pcm_valid", {63'h0, pcm_valid}, {63'h0, m_pv});
      if (m_pv) check("R7 pcm_data", {32'h0, pcm_data}, {32'h0, m_pd});
      check("R2 ctrl_word", {32'h0, ctrl_word}, {32'h0, m_ctrl});
      check("R11 ctrl_upd", {63'h0, ctrl_upd}, {63'h0, m_upd});
      check("R6 settings", {32'h0, settings}, {32'h0, m_set});
      check("R8 cap_ready", {63'h0, cap_ready}, {63'h0, !m_cfull});
      check("R5 sdout", {63'h0, sdout}, {63'h0, m_tx[63 - m_idx]});
    end
  end

  task automatic xfer(input logic [63:0] w, input int nbits, output logic [63:0] r);
    r = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      r[63-i] = sdout;
      bit_en = 1'b1; fsync = (i == 0); sdin = w[63-i];
      @(negedge clk);
      bit_en = 1'b0; fsync = 1'b0;
    end
  endtask

  task automatic push_cap(input logic [31:0] d);
    @(negedge clk);
    cap_valid = 1'b1; cap_data = d;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pcm_valid", {63'h0, pcm_valid}, 64'h0);
    check("R1 ctrl_word", {32'h0, ctrl_word}, 64'h0);
    check("R1 settings", {32'h0, settings}, 64'h0);
    check("R1 cap_ready", {63'h0, cap_ready}, 64'h1);
    check("R1 sdout", {63'h0, sdout}, 64'h0);

    // R2 / R5: arm, two further latch frames, commit
    xfer({32'h1234_5678, 32'h0}, 64, r);
    xfer({32'h5CAA_33F0, 32'h0}, 64, r);
    check("R5 status", {56'h0, r[31:24] & 8'hE4}, 64'h20);
    check("R5 version", {56'h0, r[23:16]}, 64'h02);
    check("R5 zero slots", {r[63:32], r[15:0], 16'h0}, 64'h0);
    check("R2 no commit after arm", {32'h0, ctrl_word}, 64'h0);
    xfer({32'h5C11_2233, 32'h0}, 64, r);
    check("R5 latch echo", {56'h0, r[31:24] & 8'hE4}, 64'h24);
    check("R2 no commit after one", {32'h0, ctrl_word}, 64'h0);
    xfer({32'h5FC3_4455, 32'h0}, 64, r);
    check("R2 R4 committed", {32'h0, ctrl_word}, 64'h5C83_4455);
    check("R11 pulse high", {63'h0, ctrl_upd}, 64'h1);
    @(negedge clk);
    check("R11 pulse low", {63'h0, ctrl_upd}, 64'h0);

    // R3: a clear latch bit restarts the count
    xfer({32'h0400_0000, 32'h0}, 64, r);
    xfer({32'h0000_0000, 32'h0}, 64, r);
    xfer({32'h0411_1111, 32'h0}, 64, r);
    xfer({32'h0422_2222, 32'h0}, 64, r);
    check("R3 disarmed", {32'h0, ctrl_word}, 64'h5C83_4455);
    xfer({32'h0733_3333, 32'h0}, 64, r);
    check("R3 R4 recommit", {32'h0, ctrl_word}, 64'h0433_3333);

    // R10: a short frame is ignored
    xfer({32'h0C44_4444, 32'h0}, 64, r);
    xfer({32'h0C55_5555, 32'h0}, 64, r);
    xfer({32'h0C66_6666, 32'h0}, 30, r);
    check("R10 short frame not counted", {32'h0, ctrl_word}, 64'h0433_3333);
    xfer({32'h0C77_7777, 32'h0}, 64, r);
    check("R10 commit after short", {32'h0, ctrl_word}, 64'h0C37_7777);

    // R9: mode change during a frame applies from the next one
    mode_sel = 1'b1;
    xfer({32'h1200_0001, 32'hFFFF_FFFF}, 64, r);
    check("R9 frame still control", {63'h0, pcm_valid}, 64'h0);
    check("R9 settings untouched", {32'h0, settings}, 64'h0);

    // R6 / R7 data frames under back-pressure
    adc_over = 1'b1;
    xfer({32'h1111_2222, 32'hA5FF_FF3C}, 64, r);
    check("R7 sample out", {31'h0, pcm_valid, pcm_data}, {31'h0, 1'b1, 32'h1111_2222});
    check("R6 settings masked", {32'h0, settings}, 64'hA57F_DF3C);
    adc_over = 1'b0;
    xfer({32'h3333_4444, 32'h0102_0304}, 64, r);
    check("R6 return slots", {32'h0, r[31:0]}, 64'hA57F_FF3C);
    check("R7 held under stall", {32'h0, pcm_data}, 64'h1111_2222);
    check("R6 settings update", {32'h0, settings}, 64'h0102_0304);
    @(negedge clk); pcm_ready = 1'b1;
    @(negedge clk); pcm_ready = 1'b0;
    check("R7 accepted", {63'h0, pcm_valid}, 64'h0);

    // R8 capture path
    push_cap(32'hCAFE_BEEF);
    check("R8 holding full", {63'h0, cap_ready}, 64'h0);
    xfer({32'h5555_6666, 32'h0}, 64, r);
    check("R8 consumed", {63'h0, cap_ready}, 64'h1);
    check("R7 new sample", {32'h0, pcm_data}, 64'h5555_6666);
    xfer({32'h7777_8888, 32'h0}, 64, r);
    check("R8 returned", {32'h0, r[63:32]}, 64'hCAFE_BEEF);

    // R9 back to control: return frame changes form at the boundary
    mode_sel = 1'b0;
    xfer({32'h0, 32'h0}, 64, r);
    xfer({32'h0, 32'h0}, 64, r);
    check("R9 control return", {r[63:32], 8'h0, r[23:16], 16'h0}, {32'h0, 8'h0, 8'h02, 16'h0});
    repeat (4) @(negedge clk);
    summary();
  end
endmodule